// File: doc/BRIEF.md
# Hierarchical Depth Tile Culler

This block holds one conservative depth bound for every 4x4 pixel tile of a render target and uses it to throw away whole tiles before they reach shading. Depth comparison is "nearer passes": a smaller depth value is closer to the viewer. The bound kept for a tile is therefore the farthest depth that may still be present in it. A tile whose nearest incoming pixel is not nearer than that bound cannot change any pixel, and it is rejected.

Commands arrive on one valid/ready channel. Each command carries an opcode, a tile number, sixteen 24-bit unsigned depths and a 16-bit lane enable. A test command reduces the enabled lanes to their minimum and compares that minimum with the stored bound. An update command follows the per-pixel depth test: it reduces the resolved depths to their maximum and writes the new bound. A clear command resets every bound to the far plane. Both reductions are parallel four-level trees, so each command finishes in the cycle it is accepted. A command therefore always sees the result of the command accepted before it.

Top module: `hier_depth_culler`

## Requirements
- R1: After reset, `cmd_ready_o` stays low for exactly 256 clock cycles, counted from the release of reset. `rej_valid_o` is low during that time. Afterwards every tile's bound is the far value 24'hFFFFFF.
- R2: A command is accepted only on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high. The opcode encodings are test = 0, update = 1, clear = 2 and no-op = 3. A no-op changes no bound and produces no reject.
- R3: A test takes the minimum depth over its enabled lanes and rejects exactly when that minimum is greater than or equal to the tile's stored bound. Lane i occupies bits [24*i+23 : 24*i] of `cmd_depth_i`, and bit i of `cmd_lane_en_i` enables it.
- R4: A rejected test raises `rej_valid_o` for one cycle, in the cycle after the accepting edge, with `rej_tile_o` equal to the tested tile. A passing test, an update, a clear or a no-op raises no pulse.
- R5: An update with all 16 lanes enabled replaces the tile's bound with the largest of the 16 depths. This applies even when the new bound is smaller than the old one.
- R6: An update with some lanes disabled sets the bound to the larger of the old bound and the maximum of the enabled lanes. An update with no lane enabled leaves the bound unchanged.
- R7: An accepted clear sets every bound to 24'hFFFFFF. It holds `cmd_ready_o` low for exactly 256 cycles after the accepting edge.
- R8: A test accepted on the edge right after an update of the same tile is judged against the updated bound.
- R9: An update changes the bound of the addressed tile only.
- R10: A test with no lane enabled is rejected, and a test never changes a stored bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can accept a command (low while bounds are being cleared) |
| cmd_op_i | input | 2 | Opcode: 0 test, 1 update, 2 clear, 3 no-op |
| cmd_tile_i | input | 8 | Tile number |
| cmd_depth_i | input | 384 | Sixteen 24-bit depths, lane i at bits [24i+23:24i] |
| cmd_lane_en_i | input | 16 | Per-lane enable |
| rej_valid_o | output | 1 | One-cycle pulse: the tested tile is rejected |
| rej_tile_o | output | 8 | Tile number of the rejected test |

## Verification
The stored bounds cannot be observed directly. A wrong bound shows up only as a wrong reject decision on a later test of the same tile, one cycle after that test is accepted. The bench therefore follows every change with a pair of single-lane probe tests, one at the expected bound and one just below it, which pins the stored value exactly. A sweep that is too short or too long shows up immediately as `cmd_ready_o` rising on the wrong cycle. A sweep that skips an entry shows up in the probes of tiles at both ends of the range.

// File: rtl/hzc_pkg.sv
// Shared types for the hierarchical depth tile culler.
// Assumes a 2-bit opcode field on the command channel.
package hzc_pkg;
    typedef enum logic [1:0] {
        OP_TEST   = 2'd0,
        OP_UPDATE = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_NOP    = 2'd3
    } hzc_op_e;
endpackage

// File: rtl/hzc_lane_reduce.sv
// Parallel reduction tree over LANES depth values, giving either the minimum or the maximum.
// Disabled lanes are replaced by the identity of the operation, so they never win.
// Assumes LANES is a power of two; the tree has log2(LANES) compare levels and no registers.
module hzc_lane_reduce #(
    parameter int DEPTH_W  = 24,
    parameter int LANES    = 16,
    parameter bit FIND_MAX = 1'b1
) (
    input  logic [LANES*DEPTH_W-1:0] lanes_i,
    input  logic [LANES-1:0]         en_i,
    output logic [DEPTH_W-1:0]       result_o
);
    localparam int LEVELS = $clog2(LANES);
    localparam logic [DEPTH_W-1:0] IDENT = FIND_MAX ? '0 : '1;

    // One generate level per halving of the lane count.
    for (genvar l = 0; l <= LEVELS; l++) begin : lvl_g
        logic [DEPTH_W-1:0] v [LANES>>l];
        if (l == 0) begin : leaf_g
            for (genvar j = 0; j < LANES; j++) begin : ln_g
                // Masked leaf: disabled lane takes the identity value.
                assign v[j] = en_i[j] ? lanes_i[j*DEPTH_W +: DEPTH_W] : IDENT;
            end
        end else begin : node_g
            for (genvar j = 0; j < (LANES>>l); j++) begin : pr_g
                if (FIND_MAX) begin : mx_g
                    // Pairwise maximum of two child results.
                    assign v[j] = (lvl_g[l-1].v[2*j] > lvl_g[l-1].v[2*j+1]) ?
                                  lvl_g[l-1].v[2*j] : lvl_g[l-1].v[2*j+1];
                end else begin : mn_g
                    // Pairwise minimum of two child results.
                    assign v[j] = (lvl_g[l-1].v[2*j] < lvl_g[l-1].v[2*j+1]) ?
                                  lvl_g[l-1].v[2*j] : lvl_g[l-1].v[2*j+1];
                end
            end
        end
    end

    assign result_o = lvl_g[LEVELS].v[0];

    // Checks that the tree result bounds every enabled lane (R5 for max, R3 for min).
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (en_i[j]) begin
                assert_lane_bound_R5: assert (FIND_MAX ?
                    (result_o >= lanes_i[j*DEPTH_W +: DEPTH_W]) :
                    (result_o <= lanes_i[j*DEPTH_W +: DEPTH_W]));
            end
        end
    end
endmodule

// File: rtl/hzc_bound_store.sv
// Per-tile bound storage with one combinational read port, one write port and a clear sweep.
// The sweep writes the far value to one entry per cycle, starting after reset or after a clear
// request; busy_o is high for the whole sweep and the caller must not write during it.
module hzc_bound_store #(
    parameter int DEPTH_W = 24,
    parameter int TILES   = 256,
    localparam int TILE_W = $clog2(TILES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic [TILE_W-1:0]  rd_tile_i,
    output logic [DEPTH_W-1:0] rd_bound_o,
    input  logic               wr_en_i,
    input  logic [TILE_W-1:0]  wr_tile_i,
    input  logic [DEPTH_W-1:0] wr_bound_i,
    output logic               busy_o
);
    localparam logic [DEPTH_W-1:0] FAR       = '1;
    localparam logic [TILE_W-1:0]  LAST_TILE = TILE_W'(TILES-1);
    localparam logic [TILE_W:0]    SWEEP_LEN = (TILE_W+1)'(TILES);

    logic [DEPTH_W-1:0] mem [TILES];
    logic [TILE_W-1:0]  sweep_ptr;
    logic               sweeping;

    // Sweep control: restart on reset or clear, stop after the last tile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping  <= 1'b1;
            sweep_ptr <= '0;
        end else if (clear_i) begin
            sweeping  <= 1'b1;
            sweep_ptr <= '0;
        end else if (sweeping) begin
            sweep_ptr <= sweep_ptr + 1'b1;
            if (sweep_ptr == LAST_TILE) sweeping <= 1'b0;
        end
    end

    // Storage write: the sweep has priority over normal updates.
    always_ff @(posedge clk) begin
        if (sweeping)     mem[sweep_ptr] <= FAR;
        else if (wr_en_i) mem[wr_tile_i] <= wr_bound_i;
    end

    assign rd_bound_o = mem[rd_tile_i];
    assign busy_o     = sweeping;

    // Checker counter: number of busy cycles in the current sweep.
    logic [TILE_W:0] chk_sweep_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) chk_sweep_cnt <= '0;
        else if (sweeping)     chk_sweep_cnt <= chk_sweep_cnt + 1'b1;
    end

    assert_sweep_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweeping) |-> chk_sweep_cnt == SWEEP_LEN);

    assert_no_write_in_sweep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> !wr_en_i);
endmodule

// File: rtl/hier_depth_culler.sv
// Top level of the hierarchical depth tile culler.
// One command per cycle: test (min-reduce and compare with the stored bound), update
// (max-reduce, merge with the old bound for partial coverage, write back), or clear.
// Assumes smaller depth is nearer and that "nearer passes"; the stored bound is the tile's maximum.
module hier_depth_culler
    import hzc_pkg::*;
#(
    parameter int DEPTH_W = 24,
    parameter int LANES   = 16,
    parameter int TILES   = 256,
    localparam int TILE_W = $clog2(TILES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid_i,
    output logic                     cmd_ready_o,
    input  logic [1:0]               cmd_op_i,
    input  logic [TILE_W-1:0]        cmd_tile_i,
    input  logic [LANES*DEPTH_W-1:0] cmd_depth_i,
    input  logic [LANES-1:0]         cmd_lane_en_i,
    output logic                     rej_valid_o,
    output logic [TILE_W-1:0]        rej_tile_o
);
    hzc_op_e            op;
    logic               busy;
    logic               accept;
    logic               do_test;
    logic               do_update;
    logic               do_clear;
    logic [DEPTH_W-1:0] near_min;
    logic [DEPTH_W-1:0] far_max;
    logic [DEPTH_W-1:0] old_bound;
    logic [DEPTH_W-1:0] new_bound;
    logic               culled;

    assign op          = hzc_op_e'(cmd_op_i);
    assign cmd_ready_o = !busy;
    assign accept      = cmd_valid_i && cmd_ready_o;
    assign do_test     = accept && (op == OP_TEST);
    assign do_update   = accept && (op == OP_UPDATE);
    assign do_clear    = accept && (op == OP_CLEAR);

    hzc_lane_reduce #(.DEPTH_W(DEPTH_W), .LANES(LANES), .FIND_MAX(1'b0)) u_min_tree (
        .lanes_i  (cmd_depth_i),
        .en_i     (cmd_lane_en_i),
        .result_o (near_min)
    );

    hzc_lane_reduce #(.DEPTH_W(DEPTH_W), .LANES(LANES), .FIND_MAX(1'b1)) u_max_tree (
        .lanes_i  (cmd_depth_i),
        .en_i     (cmd_lane_en_i),
        .result_o (far_max)
    );

    hzc_bound_store #(.DEPTH_W(DEPTH_W), .TILES(TILES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (do_clear),
        .rd_tile_i  (cmd_tile_i),
        .rd_bound_o (old_bound),
        .wr_en_i    (do_update),
        .wr_tile_i  (cmd_tile_i),
        .wr_bound_i (new_bound),
        .busy_o     (busy)
    );

    // Bound merge: full coverage replaces, partial coverage can only raise the bound.
    always_comb begin
        if (&cmd_lane_en_i)          new_bound = far_max;
        else if (far_max > old_bound) new_bound = far_max;
        else                          new_bound = old_bound;
    end

    assign culled = (near_min >= old_bound);

    // Reject pulse register: one cycle per rejected test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_valid_o <= 1'b0;
            rej_tile_o  <= '0;
        end else begin
            rej_valid_o <= do_test && culled;
            if (do_test) rej_tile_o <= cmd_tile_i;
        end
    end

    assert_pulse_from_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid_o |-> $past(cmd_valid_i && cmd_ready_o && cmd_op_i == 2'd0));

    assert_pulse_tile_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid_o |-> rej_tile_o == $past(cmd_tile_i));
endmodule

// File: tb/tb_hier_depth_culler.sv
module tb_hier_depth_culler;
    localparam int DW = 24;
    localparam int NL = 16;
    localparam int NT = 256;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid_i = 1'b0;
    logic           cmd_ready_o;
    logic [1:0]     cmd_op_i = '0;
    logic [7:0]     cmd_tile_i = '0;
    logic [NL*DW-1:0] cmd_depth_i = '0;
    logic [NL-1:0]  cmd_lane_en_i = '0;
    logic           rej_valid_o;
    logic [7:0]     rej_tile_o;

    hier_depth_culler dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_op_i(cmd_op_i), .cmd_tile_i(cmd_tile_i), .cmd_depth_i(cmd_depth_i),
        .cmd_lane_en_i(cmd_lane_en_i), .rej_valid_o(rej_valid_o), .rej_tile_o(rej_tile_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int         due;
        logic       rej;
        logic [7:0] tile;
        string      req;
    } exp_t;

    exp_t        sb[$];
    logic [DW-1:0] model [NT];
    logic [DW-1:0] ld [NL];
    logic [NL-1:0] len;
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Driver: waits for ready, drives one command, predicts its reject result.
    task automatic send(input logic [1:0] op, input int tile, input string req);
        logic [DW-1:0] mn, mx;
        logic rej;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        while (!cmd_ready_o) @(negedge clk);
        for (int i = 0; i < NL; i++) cmd_depth_i[i*DW +: DW] = ld[i];
        cmd_lane_en_i = len;
        cmd_op_i = op;
        cmd_tile_i = tile[7:0];
        cmd_valid_i = 1'b1;
        mn = '1;
        mx = '0;
        for (int i = 0; i < NL; i++) begin
            if (len[i]) begin
                if (ld[i] < mn) mn = ld[i];
                if (ld[i] > mx) mx = ld[i];
            end
        end
        rej = 1'b0;
        case (op)
            2'd0: rej = (mn >= model[tile]);
            2'd1: model[tile] = (&len) ? mx : ((mx > model[tile]) ? mx : model[tile]);
            2'd2: for (int t = 0; t < NT; t++) model[t] = '1;
            default: ;
        endcase
        sb.push_back('{cyc + 1, rej, tile[7:0], req});
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic probe(input int tile, input logic [DW-1:0] d, input string req);
        for (int i = 0; i < NL; i++) ld[i] = '0;
        ld[0] = d;
        len = 16'h0001;
        send(2'd0, tile, req);
    endtask

    // Probes at the expected bound (reject) and just below it (pass).
    task automatic probe_pair(input int tile, input string req);
        logic [DW-1:0] b;
        b = model[tile];
        probe(tile, b, req);
        if (b != 0) probe(tile, b - 1'b1, req);
    endtask

    task automatic fill(input logic [DW-1:0] base, input int step);
        for (int i = 0; i < NL; i++) ld[i] = base + DW'(i * step);
        len = '1;
    endtask

    // Monitor: pops scoreboard items on their due cycle, flags stray pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (rej_valid_o !== e.rej || (e.rej && rej_tile_o !== e.tile)) begin
                    bad++;
                    $display("FAIL %s: reject act=%0b/%0d exp=%0b/%0d",
                             e.req, rej_valid_o, rej_tile_o, e.rej, e.tile);
                end
            end else if (rej_valid_o !== 1'b0) begin
                total++;
                bad++;
                $display("FAIL R4: stray reject act=%0b/%0d exp=0", rej_valid_o, rej_tile_o);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int t = 0; t < NT; t++) model[t] = '1;
        for (int i = 0; i < NL; i++) ld[i] = '0;
        len = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: ready low for 256 cycles after reset release, no reject pulse.
        check(rej_valid_o == 1'b0, "R1 reject idle", int'(rej_valid_o), 0);
        cnt = 0;
        while (!cmd_ready_o) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == NT, "R1 ready delay", cnt, NT);
        probe_pair(0, "R1");
        probe_pair(255, "R1");

        // R5: full update, then R8 back-to-back test of the same tile.
        fill(24'h100000, 16);
        ld[9] = 24'h345678;
        send(2'd1, 5, "R5");
        fill(24'h345678, 0);
        send(2'd0, 5, "R8");
        fill(24'h700000, 3);
        ld[13] = 24'h345677;
        send(2'd0, 5, "R3");
        probe_pair(5, "R5");
        fill(24'h000200, 1);
        send(2'd1, 5, "R5");
        probe_pair(5, "R5");

        // R6: partial updates raise only; empty update keeps the bound.
        fill(24'h000900, 0);
        len = 16'h00F0;
        send(2'd1, 5, "R6");
        probe_pair(5, "R6");
        fill(24'h000050, 0);
        len = 16'h0003;
        send(2'd1, 5, "R6");
        probe_pair(5, "R6");
        fill(24'h000001, 0);
        len = 16'h0000;
        send(2'd1, 5, "R6");
        probe_pair(5, "R6");

        // R9: neighbours untouched.
        probe_pair(4, "R9");
        probe_pair(6, "R9");

        // R10: empty test rejects and leaves the bound.
        fill(24'h000000, 0);
        len = 16'h0000;
        send(2'd0, 5, "R10");
        probe_pair(5, "R10");

        // R2: no-op has no effect.
        fill(24'h000003, 0);
        send(2'd3, 5, "R2");
        probe_pair(5, "R2");

        // R7: clear sweep length and far bounds.
        fill(24'h000000, 0);
        send(2'd2, 0, "R7");
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cnt = 0;
        while (!cmd_ready_o) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == NT, "R7 clear delay", cnt, NT);
        probe_pair(5, "R7");
        probe_pair(255, "R7");

        // Mixed traffic on a few tiles (R3, R6).
        for (int k = 0; k < 400; k++) begin
            int t;
            int op;
            t = $urandom_range(0, 3);
            op = $urandom_range(0, 1);
            for (int i = 0; i < NL; i++) ld[i] = DW'($urandom_range(0, 4095));
            len = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom());
            send(op[1:0], t, (op == 0) ? "R3" : "R6");
        end
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule